// File: doc/BRIEF.md
# Frequency Source Selection Controller

This block decides which frequency setting drives a clock synthesizer. In the first clock cycle after reset is released it captures a 5-bit strap value. From then on it combines that strap value with a software-written configuration to produce three things: the active 5-bit ratio index, the active divider pair N and M, and a flag that marks programmable mode. The configuration consists of an override bit, a programmable-enable bit, a 5-bit select code and the N/M pair. The synthesizer computes its output as Fcpu = G·(N+3)/(M+3), where G is the gear constant picked by the ratio index.

Configuration arrives as a stream of write beats on a valid/ready channel. The last beat of a register-write transaction is marked with a last flag. All beats of a transaction are collected in a shadow copy, and the whole transaction is applied at once on its last beat. This lets a multi-byte update of N and M be checked for validity as a pair. It also means the transaction raises at most one frequency-change pulse.

On back-pressure: ready stays low until the straps have been captured, and it is held high from then on. A beat is accepted in every cycle in which valid and ready are both high. The sender may leave idle cycles between the beats of a transaction.

Top module: `freq_src_sel`

## Requirements
- R1: In the first rising clock edge after reset is released, the block captures `strap_i` into `strap_o`. `strap_o` then never changes until the next reset.
- R2: `wr_ready` is low during reset and in the capture cycle. It is high from the cycle after capture onwards. A beat is accepted on each edge where `wr_valid` and `wr_ready` are both high.
- R3: The field code in `wr_field` selects the target of a beat: 0 is control (data bit 0 is override, data bit 1 is programmable enable), 1 is the select code (data bits 4:0), 2 is N (data bits 7:0) and 3 is M (data bits 6:0). Beats without `wr_last` do not change any output. The outputs take the new values right after the edge that accepts the beat with `wr_last` high.
- R4: When programmable enable is 0, `prog_mode_o` is 0 and `n_val_o` and `m_val_o` are both 0.
- R5: When override is 0, `ratio_idx_o` equals the captured straps. When override is 1, it equals the select code. This holds in both modes. With programmable enable set, `prog_mode_o` is 1 and `n_val_o`/`m_val_o` show the active pair.
- R6: A transaction that writes N or M is checked at commit. If N+3 is greater than M+3 (that is, N > M), the pending pair becomes active and `nm_err_o` goes to 0. Otherwise `nm_err_o` goes to 1 and the previous pair stays active. N equal to M counts as invalid. A transaction that writes neither N nor M leaves `nm_err_o` unchanged.
- R7: `freq_chg_o` is high for exactly one cycle, right after a committing edge, and only if the committed setting differs from the previous one. The setting here is ratio index, mode and the output N and M. A rewrite of the same values raises no pulse. A transaction of several beats raises at most one pulse.
- R8: After reset, override, programmable enable, select code, N and M are all 0, `nm_err_o` is 0 and `freq_chg_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 5 | Frequency strap pins, captured once after reset |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat ready (high once straps are captured) |
| wr_last | input | 1 | Marks the final beat of a transaction |
| wr_field | input | 2 | Target field code of the beat |
| wr_data | input | 8 | Beat data |
| strap_o | output | 5 | Captured strap value, read-only |
| ratio_idx_o | output | 5 | Active ratio/gear index |
| prog_mode_o | output | 1 | Programmable divider mode active |
| n_val_o | output | 8 | Active N (0 when not programmable) |
| m_val_o | output | 7 | Active M (0 when not programmable) |
| nm_err_o | output | 1 | Last N/M commit was an invalid pair |
| freq_chg_o | output | 1 | One-cycle pulse on a change of the effective setting |

## Verification
The hardest situations to reach are those where two writes inside one transaction interact. One is a word-style update in which the intermediate pair would be invalid but the final pair is valid. The other is the reverse case: a final pair that is invalid, where the old pair must survive. The stimulus reaches both with multi-beat transactions that leave idle cycles between beats. During each idle cycle the bench confirms that no output has moved. It then targets the N equal to M boundary and a write of N alone while programmable mode is off, which must raise no change pulse.

// File: rtl/fss_pkg.sv
package fss_pkg;
  typedef enum logic [1:0] {
    FLD_CTRL = 2'd0,
    FLD_SEL  = 2'd1,
    FLD_NVAL = 2'd2,
    FLD_MVAL = 2'd3
  } fld_e;

  localparam int CTRL_OVR_BIT = 0;
  localparam int CTRL_PEN_BIT = 1;
endpackage

// File: rtl/fss_strap_latch.sv
module fss_strap_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] strap_i,
  output logic [W-1:0] strap_q,
  output logic         done_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q <= '0;
      done_q  <= 1'b0;
    end else if (!done_q) begin
      strap_q <= strap_i;
      done_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/fss_cfg_shadow.sv
module fss_cfg_shadow
  import fss_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int N_W    = 8,
  parameter int M_W    = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              last,
  input  fld_e              field,
  input  logic [DATA_W-1:0] data,
  output logic              ovr_q,
  output logic              pen_q,
  output logic [IDX_W-1:0]  sel_q,
  output logic [N_W-1:0]    n_q,
  output logic [M_W-1:0]    m_q,
  output logic              err_q,
  output logic              commit
);
  localparam int CW = (N_W > M_W) ? N_W : M_W;

  logic             sh_ovr, sh_pen, sh_touch;
  logic [IDX_W-1:0] sh_sel;
  logic [N_W-1:0]   sh_n;
  logic [M_W-1:0]   sh_m;

  logic             nx_ovr, nx_pen, nx_touch;
  logic [IDX_W-1:0] nx_sel;
  logic [N_W-1:0]   nx_n;
  logic [M_W-1:0]   nx_m;
  logic             pair_ok;
  logic [N_W-1:0]   cm_n;
  logic [M_W-1:0]   cm_m;

  assign commit = beat && last;

  always_comb begin
    nx_ovr   = sh_ovr;
    nx_pen   = sh_pen;
    nx_sel   = sh_sel;
    nx_n     = sh_n;
    nx_m     = sh_m;
    nx_touch = sh_touch;
    if (beat) begin
      unique case (field)
        FLD_CTRL: begin
          nx_ovr = data[CTRL_OVR_BIT];
          nx_pen = data[CTRL_PEN_BIT];
        end
        FLD_SEL:  nx_sel = data[IDX_W-1:0];
        FLD_NVAL: begin
          nx_n     = data[N_W-1:0];
          nx_touch = 1'b1;
        end
        FLD_MVAL: begin
          nx_m     = data[M_W-1:0];
          nx_touch = 1'b1;
        end
      endcase
    end
  end

  assign pair_ok = CW'(nx_n) > CW'(nx_m);
  assign cm_n    = (nx_touch && pair_ok) ? nx_n : n_q;
  assign cm_m    = (nx_touch && pair_ok) ? nx_m : m_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0; pen_q <= 1'b0; sel_q <= '0;
      n_q <= '0; m_q <= '0; err_q <= 1'b0;
      sh_ovr <= 1'b0; sh_pen <= 1'b0; sh_sel <= '0;
      sh_n <= '0; sh_m <= '0; sh_touch <= 1'b0;
    end else if (commit) begin
      ovr_q <= nx_ovr;
      pen_q <= nx_pen;
      sel_q <= nx_sel;
      n_q   <= cm_n;
      m_q   <= cm_m;
      if (nx_touch) err_q <= !pair_ok;
      sh_ovr <= nx_ovr;
      sh_pen <= nx_pen;
      sh_sel <= nx_sel;
      sh_n   <= cm_n;
      sh_m   <= cm_m;
      sh_touch <= 1'b0;
    end else if (beat) begin
      sh_ovr <= nx_ovr;
      sh_pen <= nx_pen;
      sh_sel <= nx_sel;
      sh_n   <= nx_n;
      sh_m   <= nx_m;
      sh_touch <= nx_touch;
    end
  end
endmodule

// File: rtl/fss_src_select.sv
module fss_src_select #(
  parameter int IDX_W = 5,
  parameter int N_W   = 8,
  parameter int M_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [IDX_W-1:0] strap,
  input  logic             ovr,
  input  logic             pen,
  input  logic [IDX_W-1:0] sel,
  input  logic [N_W-1:0]   n_act,
  input  logic [M_W-1:0]   m_act,
  output logic [IDX_W-1:0] idx_o,
  output logic             mode_o,
  output logic [N_W-1:0]   n_o,
  output logic [M_W-1:0]   m_o,
  output logic             chg_o
);
  localparam int EFF_W = IDX_W + 1 + N_W + M_W;

  logic [EFF_W-1:0] eff, eff_q;
  logic             commit_d;

  assign idx_o  = ovr ? sel : strap;
  assign mode_o = pen;
  assign n_o    = pen ? n_act : '0;
  assign m_o    = pen ? m_act : '0;
  assign eff    = {idx_o, mode_o, n_o, m_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q    <= '0;
      commit_d <= 1'b0;
    end else begin
      eff_q    <= eff;
      commit_d <= commit;
    end
  end

  assign chg_o = commit_d && (eff != eff_q);
endmodule

// File: rtl/freq_src_sel.sv
module freq_src_sel
  import fss_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int N_W    = 8,
  parameter int M_W    = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  strap_i,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_last,
  input  logic [1:0]        wr_field,
  input  logic [DATA_W-1:0] wr_data,
  output logic [IDX_W-1:0]  strap_o,
  output logic [IDX_W-1:0]  ratio_idx_o,
  output logic              prog_mode_o,
  output logic [N_W-1:0]    n_val_o,
  output logic [M_W-1:0]    m_val_o,
  output logic              nm_err_o,
  output logic              freq_chg_o
);
  logic             strap_ok, beat, commit;
  logic             ovr, pen;
  logic [IDX_W-1:0] sel;
  logic [N_W-1:0]   n_act;
  logic [M_W-1:0]   m_act;

  assign wr_ready = strap_ok;
  assign beat     = wr_valid && wr_ready;

  fss_strap_latch #(.W(IDX_W)) u_strap (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i),
    .strap_q(strap_o), .done_q(strap_ok)
  );

  fss_cfg_shadow #(.IDX_W(IDX_W), .N_W(N_W), .M_W(M_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .beat(beat), .last(wr_last),
    .field(fld_e'(wr_field)), .data(wr_data),
    .ovr_q(ovr), .pen_q(pen), .sel_q(sel), .n_q(n_act), .m_q(m_act),
    .err_q(nm_err_o), .commit(commit)
  );

  fss_src_select #(.IDX_W(IDX_W), .N_W(N_W), .M_W(M_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .commit(commit), .strap(strap_o),
    .ovr(ovr), .pen(pen), .sel(sel), .n_act(n_act), .m_act(m_act),
    .idx_o(ratio_idx_o), .mode_o(prog_mode_o), .n_o(n_val_o), .m_o(m_val_o),
    .chg_o(freq_chg_o)
  );
endmodule

// File: rtl/freq_src_sel_chk.sv
module freq_src_sel_chk #(
  parameter int IDX_W = 5,
  parameter int N_W   = 8,
  parameter int M_W   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             strap_ok,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             wr_last,
  input logic [IDX_W-1:0] strap_o,
  input logic [IDX_W-1:0] ratio_idx_o,
  input logic             prog_mode_o,
  input logic [N_W-1:0]   n_val_o,
  input logic [M_W-1:0]   m_val_o,
  input logic             freq_chg_o
);
  localparam int CW = (N_W > M_W) ? N_W : M_W;
  logic acc_last;
  assign acc_last = wr_valid && wr_ready && wr_last;

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_ok && $past(strap_ok)) |-> $stable(strap_o)) else $error("strap moved"); // R1

  AST_NOPROG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_mode_o |-> (n_val_o == '0 && m_val_o == '0)) else $error("divider leak"); // R4

  AST_PAIR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_mode_o && (n_val_o != '0 || m_val_o != '0)) |-> (CW'(n_val_o) > CW'(m_val_o)))
    else $error("invalid pair active"); // R6

  AST_PULSE_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    freq_chg_o |-> $past(acc_last)) else $error("stray pulse"); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_ok && $past(strap_ok) && !$past(acc_last)) |->
      ($stable(ratio_idx_o) && $stable(prog_mode_o) && $stable(n_val_o) && $stable(m_val_o)))
    else $error("output moved without commit"); // R3
endmodule

bind freq_src_sel freq_src_sel_chk #(.IDX_W(IDX_W), .N_W(N_W), .M_W(M_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strap_ok(strap_ok), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_last(wr_last), .strap_o(strap_o),
  .ratio_idx_o(ratio_idx_o), .prog_mode_o(prog_mode_o), .n_val_o(n_val_o),
  .m_val_o(m_val_o), .freq_chg_o(freq_chg_o)
);

// File: tb/sim_freq_src_sel.sv
module sim_freq_src_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] strap_i = 5'h13;
  logic       wr_valid = 1'b0, wr_last = 1'b0;
  logic       wr_ready;
  logic [1:0] wr_field = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [4:0] strap_o, ratio_idx_o;
  logic       prog_mode_o, nm_err_o, freq_chg_o;
  logic [7:0] n_val_o;
  logic [6:0] m_val_o;

  always #2 clk = ~clk;

  freq_src_sel u0 (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_last(wr_last), .wr_field(wr_field), .wr_data(wr_data),
    .strap_o(strap_o), .ratio_idx_o(ratio_idx_o), .prog_mode_o(prog_mode_o),
    .n_val_o(n_val_o), .m_val_o(m_val_o), .nm_err_o(nm_err_o), .freq_chg_o(freq_chg_o)
  );

  typedef struct packed {
    logic [4:0] idx; logic p; logic [7:0] n; logic [6:0] m; logic e; logic c;
  } exp_t;

  exp_t q[$];
  int   errors = 0, checks = 0;
  logic done = 1'b0;

  // model state
  logic       m_ovr = 0, m_pen = 0, m_err = 0;
  logic [4:0] m_sel = 0;
  logic [7:0] m_n = 0;
  logic [6:0] m_m = 0;
  logic [4:0] m_strap = 5'h13;
  logic [1:0] bf[4];
  logic [7:0] bd[4];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t cur_exp(input logic c);
    exp_t x;
    x.idx = m_ovr ? m_sel : m_strap;
    x.p   = m_pen;
    x.n   = m_pen ? m_n : 8'd0;
    x.m   = m_pen ? m_m : 7'd0;
    x.e   = m_err;
    x.c   = c;
    return x;
  endfunction

  task automatic send(input int cnt);
    exp_t old, nw;
    logic so, sp, st;
    logic [4:0] ss;
    logic [7:0] sn;
    logic [6:0] sm;
    old = cur_exp(1'b0);
    so = m_ovr; sp = m_pen; ss = m_sel; sn = m_n; sm = m_m; st = 0;
    for (int i = 0; i < cnt; i++) begin
      case (bf[i])
        2'd0: begin so = bd[i][0]; sp = bd[i][1]; end
        2'd1: ss = bd[i][4:0];
        2'd2: begin sn = bd[i]; st = 1; end
        default: begin sm = bd[i][6:0]; st = 1; end
      endcase
      if (i == cnt - 1) begin
        m_ovr = so; m_pen = sp; m_sel = ss;
        if (st) begin
          if ({1'b0, sn} > {2'b0, sm}) begin m_n = sn; m_m = sm; m_err = 0; end
          else m_err = 1;
        end
        nw = cur_exp(1'b0);
        nw.c = ({nw.idx, nw.p, nw.n, nw.m} != {old.idx, old.p, old.n, old.m});
        q.push_back(nw);
      end
      @(negedge clk);
      wr_valid = 1; wr_field = bf[i]; wr_data = bd[i]; wr_last = (i == cnt - 1);
      @(negedge clk);
      wr_valid = 0; wr_last = 0;
      if (i != cnt - 1) begin
        // R3: no output change mid-transaction
        check("R3 mid idx", ratio_idx_o, old.idx);
        check("R3 mid n", n_val_o, old.n);
        check("R7 mid no pulse", freq_chg_o, 0);
      end
    end
    repeat (3) @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && wr_valid && wr_ready && wr_last) begin
        exp_t e;
        @(negedge clk);
        e = q.pop_front();
        check("R5 idx", ratio_idx_o, e.idx);
        check("R5 mode", prog_mode_o, e.p);
        check("R4/R5 n", n_val_o, e.n);
        check("R4/R5 m", m_val_o, e.m);
        check("R6 err", nm_err_o, e.e);
        check("R7 pulse", freq_chg_o, e.c);
        @(negedge clk);
        check("R7 single cycle", freq_chg_o, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 ready in reset", wr_ready, 0);
    check("R8 idx", ratio_idx_o, 0);
    check("R8 err", nm_err_o, 0);
    check("R8 chg", freq_chg_o, 0);
    check("R8 n", n_val_o, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 strap captured", strap_o, 5'h13);
    check("R2 ready after capture", wr_ready, 1);
    check("R5 idx from straps", ratio_idx_o, 5'h13);
    strap_i = 5'h04;
    repeat (4) @(negedge clk);
    check("R1 strap held", strap_o, 5'h13);
    check("R1 idx held", ratio_idx_o, 5'h13);

    bf[0] = 2'd1; bd[0] = 8'h0A; send(1);                 // sel w/o override
    bf[0] = 2'd0; bd[0] = 8'h01; send(1);                 // override on
    bf[0] = 2'd2; bd[0] = 8'h50; send(1);                 // R4: N while prog off
    bf[0] = 2'd0; bd[0] = 8'h03; send(1);                 // prog on
    bf[0] = 2'd2; bd[0] = 8'h61; bf[1] = 2'd3; bd[1] = 8'h2D; send(2);
    bf[0] = 2'd2; bd[0] = 8'h20; bf[1] = 2'd3; bd[1] = 8'h40; send(2); // R6 invalid
    bf[0] = 2'd3; bd[0] = 8'h61; send(1);                 // R6 N==M boundary
    bf[0] = 2'd3; bd[0] = 8'h60; send(1);                 // valid again
    bf[0] = 2'd2; bd[0] = 8'h61; send(1);                 // R7 same value
    bf[0] = 2'd0; bd[0] = 8'h02; send(1);                 // straps idx, prog on
    bf[0] = 2'd0; bd[0] = 8'h00; bf[1] = 2'd1; bd[1] = 8'h05;
    bf[2] = 2'd2; bd[2] = 8'h07; bf[3] = 2'd3; bd[3] = 8'h01; send(4);
    bf[0] = 2'd0; bd[0] = 8'h01; send(1);
    check("R1 strap final", strap_o, 5'h13);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule